// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog Reset

This block is a memory-mapped operating-system timer. It has one 32-bit up-counter that advances by one on each clock cycle in which the tick-enable input is high. Software can load the counter through the register port. Four 32-bit compare registers watch that counter. When a tick brings the counter equal to compare value i, channel i raises its status bit and its interrupt line, but only if the channel's interrupt enable is set. Software clears a status bit, and the interrupt line that goes with it, by writing a one to that bit.

Channel 3 also serves as a watchdog. If the watchdog register's arm bit is set when channel 3 matches, the block emits a one-cycle reset-request pulse. The same match clears the whole watchdog register, so the request is issued only once. The register port is synchronous and addressed by 32-bit word. Writes take effect at the clock edge. Read data is registered and appears in the cycle after the read strobe.

The watchdog is a three-state machine. WD_OFF is the disarmed state. WD_ARMED waits for a channel-3 match. WD_FIRE lasts one cycle and drives the reset request. The transitions are:
- WD_OFF to WD_ARMED when the watchdog register is written with bit 0 set.
- WD_ARMED to WD_OFF when it is written with bit 0 clear.
- WD_ARMED to WD_FIRE on a channel-3 match. This transition takes priority over a write in the same cycle.
- WD_FIRE to WD_ARMED if a write in that cycle sets bit 0, and to WD_OFF otherwise.

Top module: `os_match_timer`

## Requirements
- R1: After reset, every register reads 0: the four compare registers, the counter, status, watchdog and interrupt enable. The irq outputs and wdog_rst are also 0.
- R2: In each cycle with tick_en high and no counter write, the counter increases by 1 and wraps from 0xFFFFFFFF to 0. With tick_en low, the counter holds its value.
- R3: A write to word 4 loads the counter and overrides a tick in the same cycle. A load never produces a match, even when the loaded value equals a compare register.
- R4: A tick that makes the counter equal to the compare register at word i (i = 0..3), with interrupt-enable bit i set, sets status bit i and irq[i] at that same clock edge.
- R5: A channel whose interrupt-enable bit is 0 sets neither its status bit nor its irq line when it matches.
- R6: Writing word 5 clears each status bit (bits 0..3) that is written as 1 and leaves the others unchanged. irq[i] always follows status bit i. A match in the same cycle as a clearing write leaves that bit set.
- R7: Word 7 (interrupt enable) stores bits 11:0 and reads bits 31:12 as 0. Word 5 reads bits 31:4 as 0.
- R8: If watchdog bit 0 is 1 when channel 3 matches, wdog_rst is high for exactly one cycle, at the same time the status becomes visible. The watchdog register then reads 0, so a later match gives no pulse. This holds whatever channel 3's interrupt enable is.
- R9: With watchdog bit 0 at 0, a channel-3 match gives no pulse. All 32 bits of word 6 are stored and read back.
- R10: A read of word 8 to 15 returns 0. A write to those words changes no register.
- R11: A match is reported once for each tick that reaches the compare value. A counter that rests on the compare value does not set a cleared status bit again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable, one count per cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address (0-3 compare, 4 counter, 5 status, 6 watchdog, 7 interrupt enable) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after rd_en |
| irq | output | 4 | Per-channel level interrupts |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The bench sweeps all 16 interrupt-enable patterns with counter bases that cross the 32-bit wrap point, so that a compare against the pre-tick counter value or a missed wrap shows up as a wrong status word. It targets the case where a status clear and a fresh match arrive together: a design that lets the clear win would drop an interrupt. It also targets a counter load onto the compare value: a design that compares any new counter value would raise a spurious interrupt. It counts watchdog pulses across two channel-3 matches, so a watchdog that does not clear itself, or that fires while disarmed, shows an extra pulse. Unmapped writes are followed by a full register readback to show that nothing aliased.

// File: rtl/ostm_pkg.sv
package ostm_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int NCH    = 4;
    localparam int IER_W  = 12;

    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_WDOG   = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_IER    = ADDR_W'(7);

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_t;
endpackage

// File: rtl/ostm_counter.sv
module ostm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_inc,
    output logic         adv
);
    assign cnt_inc = cnt + W'(1);
    assign adv     = tick && !load;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick)
            cnt <= cnt_inc;
    end
endmodule

// File: rtl/ostm_match_bank.sv
module ostm_match_bank #(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   wr_sel,
    input  logic [W-1:0]   wdata,
    input  logic           adv,
    input  logic [W-1:0]   cnt_inc,
    output logic [N*W-1:0] match_flat,
    output logic [N-1:0]   hit
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic [W-1:0] match_q;

        always_ff @(posedge clk) begin
            if (!rst_n)
                match_q <= '0;
            else if (wr_sel[g])
                match_q <= wdata;
        end

        assign match_flat[g*W +: W] = match_q;
        assign hit[g] = adv && (cnt_inc == match_q);
    end
endmodule

// File: rtl/ostm_watchdog.sv
module ostm_watchdog
    import ostm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         hit,
    output logic [W-1:0] value,
    output logic         pulse
);
    wd_state_t    state_q, state_d;
    logic [W-1:1] upper_q;
    logic         fire;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= WD_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:   if (wr && wdata[0]) state_d = WD_ARMED;
            WD_ARMED: begin
                if (hit)
                    state_d = WD_FIRE;
                else if (wr && !wdata[0])
                    state_d = WD_OFF;
            end
            WD_FIRE:  state_d = (wr && wdata[0]) ? WD_ARMED : WD_OFF;
            default:  state_d = WD_OFF;
        endcase
    end

    assign fire = (state_q == WD_ARMED) && hit;

    always_ff @(posedge clk) begin
        if (!rst_n)
            upper_q <= '0;
        else if (fire)
            upper_q <= '0;
        else if (wr)
            upper_q <= wdata[W-1:1];
    end

    always_comb begin
        pulse = (state_q == WD_FIRE);
        value = {upper_q, state_q == WD_ARMED};
    end
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
    import ostm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    irq,
    output logic              wdog_rst
);
    localparam int WD_CH = NCH - 1;

    logic [DATA_W-1:0]     cnt_q, cnt_inc;
    logic                  adv;
    logic [NCH*DATA_W-1:0] match_flat;
    logic [NCH-1:0]        hit, mwr_sel;
    logic [IER_W-1:0]      ier_q;
    logic [NCH-1:0]        stat_q, stat_clr;
    logic [DATA_W-1:0]     wd_val;
    logic [DATA_W-1:0]     rd_val;
    logic                  cnt_wr, st_wr, wd_wr, ier_wr;

    assign cnt_wr = wr_en && (addr == A_COUNT);
    assign st_wr  = wr_en && (addr == A_STATUS);
    assign wd_wr  = wr_en && (addr == A_WDOG);
    assign ier_wr = wr_en && (addr == A_IER);

    for (genvar g = 0; g < NCH; g++) begin : g_sel
        assign mwr_sel[g] = wr_en && (addr == ADDR_W'(g));
    end

    ostm_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .load(cnt_wr),
        .load_val(wdata), .cnt(cnt_q), .cnt_inc(cnt_inc), .adv(adv)
    );

    ostm_match_bank #(.N(NCH), .W(DATA_W)) u_match (
        .clk(clk), .rst_n(rst_n), .wr_sel(mwr_sel), .wdata(wdata),
        .adv(adv), .cnt_inc(cnt_inc), .match_flat(match_flat), .hit(hit)
    );

    ostm_watchdog #(.W(DATA_W)) u_wd (
        .clk(clk), .rst_n(rst_n), .wr(wd_wr), .wdata(wdata),
        .hit(hit[WD_CH]), .value(wd_val), .pulse(wdog_rst)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ier_q <= '0;
        else if (ier_wr)
            ier_q <= wdata[IER_W-1:0];
    end

    assign stat_clr = st_wr ? wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~stat_clr) | (hit & ier_q[NCH-1:0]);
    end

    assign irq = stat_q;

    always_comb begin
        rd_val = '0;
        if (addr < ADDR_W'(NCH))
            rd_val = match_flat[addr[1:0]*DATA_W +: DATA_W];
        else if (addr == A_COUNT)
            rd_val = cnt_q;
        else if (addr == A_STATUS)
            rd_val = {{(DATA_W-NCH){1'b0}}, stat_q};
        else if (addr == A_WDOG)
            rd_val = wd_val;
        else if (addr == A_IER)
            rd_val = {{(DATA_W-IER_W){1'b0}}, ier_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_val;
    end
endmodule

// File: rtl/ostm_checker.sv
module ostm_checker
    import ostm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [NCH-1:0]    irq,
    input logic              wdog_rst,
    input logic [DATA_W-1:0] cnt,
    input logic [IER_W-1:0]  ier,
    input logic [DATA_W-1:0] wd_value
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !(wr_en && addr == A_COUNT)) |=> (cnt == $past(cnt) + DATA_W'(1)));

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_COUNT) |=> (cnt == $past(wdata)));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq) & ~$past(ier[NCH-1:0])) == '0));

    // R7
    ier_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_IER) |=> (rdata[DATA_W-1:IER_W] == '0));

    // R8
    wd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);

    // R8
    wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> (wd_value == '0));
endmodule

bind os_match_timer ostm_checker chk_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst),
    .cnt(cnt_q), .ier(ier_q), .wd_value(wd_val)
);

// File: tb/os_match_timer_tb_top.sv
module os_match_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    logic        wdog_rst;

    int n_checks = 0;
    int n_fails  = 0;
    int pulses   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    os_match_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    always @(posedge clk) if (rst_n && wdog_rst) pulses++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic tick_n(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog timeout actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] v, base;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {28'd0, irq}, 32'd0);
        check("R1 wdog_rst", {31'd0, wdog_rst}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), v);
            check("R1 reg", v, 32'd0);
        end

        // R7 ier width
        wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, v);
        check("R7 ier", v, 32'h0000_0FFF);

        // R4 R5 R2: sweep all enable patterns across the wrap point
        for (int p = 0; p < 16; p++) begin
            base = 32'hFFFF_FFFD + 32'(p);
            wr(4'd7, 32'(p));
            wr(4'd5, 32'hF);
            for (int i = 0; i < 4; i++) wr(4'(i), base + 32'(1 + i));
            wr(4'd4, base);
            tick_n(4);
            check("R4/R5 irq", {28'd0, irq}, 32'(p));
            rd(4'd5, v);
            check("R4/R5 status", v, 32'(p));
            rd(4'd4, v);
            check("R2 count", v, base + 32'd4);
        end
        check("R9 no pulse while disarmed", 32'(pulses), 32'd0);

        // R7 status upper bits and R6 partial clear (status is 0xF now)
        wr(4'd5, 32'hFFFF_FFF5); rd(4'd5, v);
        check("R6 partial clear", v, 32'hA);
        check("R6 irq follows", {28'd0, irq}, 32'hA);
        check("R7 status upper", v & 32'hFFFF_FFF0, 32'd0);

        // R6 simultaneous clear and match: set wins
        wr(4'd5, 32'hF);
        wr(4'd7, 32'h1);
        wr(4'd0, 32'h100); wr(4'd4, 32'hFE);
        tick_n(1);
        @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; addr = 4'd5; wdata = 32'h1;
        @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
        check("R6 set beats clear", {28'd0, irq}, 32'h1);

        // R11 resting on compare value does not re-fire
        wr(4'd5, 32'h1);
        repeat (4) @(negedge clk);
        rd(4'd5, v);
        check("R11 no refire", v, 32'd0);

        // R3 load onto compare value with tick: load wins, no match
        @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; addr = 4'd4; wdata = 32'h100;
        @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
        rd(4'd4, v);
        check("R3 load value", v, 32'h100);
        check("R3 no match on load", {28'd0, irq}, 32'd0);

        // R9 watchdog bits stored, disarmed gives no pulse
        wr(4'd6, 32'hA0); rd(4'd6, v);
        check("R9 wdog readback", v, 32'hA0);
        p0 = pulses;
        wr(4'd7, 32'h0);
        wr(4'd3, 32'h200); wr(4'd4, 32'h1FE);
        tick_n(2);
        repeat (2) @(negedge clk);
        check("R9 no pulse", 32'(pulses - p0), 32'd0);

        // R8 armed: single pulse, self clear
        wr(4'd6, 32'hA1);
        wr(4'd4, 32'h1FE);
        p0 = pulses;
        tick_n(2);
        check("R8 pulse high", {31'd0, wdog_rst}, 32'd1);
        @(negedge clk);
        check("R8 pulse one cycle", {31'd0, wdog_rst}, 32'd0);
        check("R8 pulse count", 32'(pulses - p0), 32'd1);
        check("R8 ier ignored irq", {28'd0, irq}, 32'd0);
        rd(4'd6, v);
        check("R8 wdog cleared", v, 32'd0);
        wr(4'd4, 32'h1FE);
        tick_n(2);
        repeat (2) @(negedge clk);
        check("R8 one shot", 32'(pulses - p0), 32'd1);

        // R10 unmapped
        wr(4'd7, 32'h5A5); wr(4'd6, 32'h33C); wr(4'd4, 32'h77);
        for (int i = 0; i < 4; i++) wr(4'(i), 32'h1000 + 32'(i));
        for (int a = 8; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
        for (int i = 0; i < 4; i++) begin
            rd(4'(i), v);
            check("R10 match kept", v, 32'h1000 + 32'(i));
        end
        rd(4'd4, v); check("R10 count kept", v, 32'h77);
        rd(4'd5, v); check("R10 status kept", v, 32'd0);
        rd(4'd6, v); check("R10 wdog kept", v, 32'h33C);
        rd(4'd7, v); check("R10 ier kept", v, 32'h5A5);
        for (int a = 8; a < 16; a++) begin
            rd(4'(a), v);
            check("R10 unmapped read", v, 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule